// File: doc/BRIEF.md
# Indirectly Addressed GPIO Port

This block is an eight-pin general-purpose I/O port sitting on a small synchronous register bus. Most of its configuration sits behind an index window. A bus master first writes the number of a configuration subregister into the index register. Every later access to the window address then reads or writes that subregister, until the index is changed. The output data latch and the synchronised pin inputs sit at their own direct addresses.

Each pin has three configuration bits: direction, peripheral-function select and open-drain enable. For each pin, the select bit first picks the drive value from either the output latch or the peripheral signal. Open-drain control then acts on that value, after the selection, so peripheral outputs are affected in the same way as latch outputs. In open-drain mode a 0 pulls the pin low and a 1 releases it by dropping the pin's output enable. Pin inputs pass through a two-flop synchroniser before the bus can read them.

Top module: `gpio_idx_port`

## Requirements
- R1: After reset the index register reads 00h. Direction (index 01h) reads FFh. Peripheral select (index 02h) and open-drain (index 03h) read 00h. The output latch reads 00h and every pin_oe bit is 0.
- R2: A write to bus address 0 stores the index from the following clock edge, and address 0 reads it back. Accesses at bus address 1 reach the subregister named by the stored index until address 0 is written again.
- R3: Direction subregister (index 01h): a bit of 1 makes that pin an input, so its pin_oe is 0. A bit of 0 makes it an output.
- R4: Peripheral select subregister (index 02h): a bit of 1 makes the pin's drive value come from alt_out. A bit of 0 makes it come from the output latch.
- R5: Open-drain subregister (index 03h): for an output pin with the bit set, a drive value of 0 gives pin_oe=1 and pin_out=0, and a drive value of 1 gives pin_oe=0. With the bit clear, an output pin has pin_oe=1 and pin_out equal to the drive value.
- R6: Open-drain control applies to the drive value after the peripheral selection, so it also governs pins whose value comes from alt_out.
- R7: Through address 1, any index other than 01h–03h reads 00h. Writes to such an index change no subregister.
- R8: A level applied on pin_in appears at bus address 3 after exactly two rising clock edges, and not after one.
- R9: Bus address 2 holds the output latch, which can be both written and read back.
- R10: Bus address 3 is read-only, so a write there changes none of the port's state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 index, 1 subregister window, 2 output latch, 3 pin inputs |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data, 00h when not selected |
| pin_in | input | 8 | Raw pin levels |
| alt_out | input | 8 | Peripheral drive values, one per pin |
| pin_out | output | 8 | Value driven onto each pin |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
A stale or wrongly decoded index shows up on the very next window access. The read returns the wrong subregister, or a write lands in a subregister that a later read-back exposes. A fault in the direction, select or open-drain logic shows up combinationally on pin_out and pin_oe right after the writing edge. Those pins are checked against values derived per bit from the latch, the peripheral inputs and the configuration. The synchroniser depth is checked by reading address 3 after one edge and again after two.

// File: rtl/gpio_idx_port.sv
module gpio_idx_port #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] alt_out,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);

  localparam logic [1:0] A_INDEX = 2'd0;
  localparam logic [1:0] A_WIN   = 2'd1;
  localparam logic [1:0] A_LATCH = 2'd2;
  localparam logic [1:0] A_PINS  = 2'd3;

  localparam logic [7:0] SUB_DIR = 8'h01;
  localparam logic [7:0] SUB_ALT = 8'h02;
  localparam logic [7:0] SUB_OD  = 8'h03;

  logic [7:0]      idx_q;
  logic [NPIN-1:0] dir_q, alt_q, od_q, lat_q;
  logic [NPIN-1:0] sync1_q, sync2_q;
  logic [NPIN-1:0] drive_v;
  logic [7:0]      win_rd;

  wire wr_en  = bus_sel & bus_wr;
  wire wr_idx = wr_en & (bus_addr == A_INDEX);
  wire wr_win = wr_en & (bus_addr == A_WIN);
  wire wr_lat = wr_en & (bus_addr == A_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      dir_q <= '1;
      alt_q <= '0;
      od_q  <= '0;
      lat_q <= '0;
    end else begin
      if (wr_idx) idx_q <= bus_wdata;
      if (wr_lat) lat_q <= bus_wdata[NPIN-1:0];
      if (wr_win) begin
        case (idx_q)
          SUB_DIR: dir_q <= bus_wdata[NPIN-1:0];
          SUB_ALT: alt_q <= bus_wdata[NPIN-1:0];
          SUB_OD:  od_q  <= bus_wdata[NPIN-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    win_rd = '0;
    case (idx_q)
      SUB_DIR: win_rd[NPIN-1:0] = dir_q;
      SUB_ALT: win_rd[NPIN-1:0] = alt_q;
      SUB_OD:  win_rd[NPIN-1:0] = od_q;
      default: win_rd = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_INDEX: bus_rdata = idx_q;
        A_WIN:   bus_rdata = win_rd;
        A_LATCH: bus_rdata[NPIN-1:0] = lat_q;
        A_PINS:  bus_rdata[NPIN-1:0] = sync2_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  for (genvar b = 0; b < NPIN; b++) begin : g_pin
    assign drive_v[b] = alt_q[b] ? alt_out[b] : lat_q[b];
    assign pin_out[b] = drive_v[b] & ~od_q[b];
    assign pin_oe[b]  = ~dir_q[b] & (~od_q[b] | ~drive_v[b]);
  end

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_idx |=> $stable(idx_q)) else $error("index changed without write"); // R2

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> (idx_q == $past(bus_wdata))) else $error("index not loaded"); // R2

  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & pin_oe) == '0) else $error("input pin enabled"); // R3

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q & pin_oe & pin_out) == '0) else $error("open-drain pin drives high"); // R5

  AST_UNIMPL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && (idx_q == 8'h00 || idx_q > SUB_OD)) |=> $stable({dir_q, alt_q, od_q}))
    else $error("write to unused index changed state"); // R7

  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (sync2_q == $past(pin_in, 2))) else $error("sync depth wrong"); // R8

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lat |=> $stable(lat_q)) else $error("latch changed without write"); // R9

endmodule

// File: tb/test_gpio_idx_port.sv
module test_gpio_idx_port;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0, alt_out = '0;
  logic [7:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_idx_port i_gpio_idx_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .alt_out(alt_out), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic sub_wr(input logic [7:0] i, input logic [7:0] d);
    wr(2'd0, i);
    wr(2'd1, d);
  endtask

  task automatic sub_rd(input logic [7:0] i, output logic [7:0] d);
    wr(2'd0, i);
    rd(2'd1, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 oe", pin_oe, 8'h00);
    rd(2'd0, v);       chk("R1 index", v, 8'h00);
    sub_rd(8'h01, v);  chk("R1 dir", v, 8'hFF);
    sub_rd(8'h02, v);  chk("R1 alt", v, 8'h00);
    sub_rd(8'h03, v);  chk("R1 od", v, 8'h00);
    rd(2'd2, v);       chk("R1 latch", v, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] v;
    wr(2'd0, 8'h02);
    rd(2'd0, v);       chk("R2 index readback", v, 8'h02);
    wr(2'd1, 8'h81);
    rd(2'd1, v);       chk("R2 window same index", v, 8'h81);
    rd(2'd1, v);       chk("R2 index sticky", v, 8'h81);
    wr(2'd0, 8'h01);
    rd(2'd1, v);       chk("R2 new index dir", v, 8'hFF);
    sub_wr(8'h02, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    wr(2'd2, 8'hA5);
    rd(2'd2, v);       chk("R9 latch readback", v, 8'hA5);
    chk("R3 all inputs oe", pin_oe, 8'h00);
    sub_wr(8'h01, 8'h00);
    #1 chk("R3 all outputs oe", pin_oe, 8'hFF);
    chk("R5 push-pull value", pin_out, 8'hA5);
    sub_wr(8'h01, 8'h0F);
    #1 chk("R3 half inputs oe", pin_oe, 8'hF0);
    sub_wr(8'h01, 8'h00);
  endtask

  task automatic t_alt();
    alt_out = 8'h3C;
    sub_wr(8'h02, 8'hF0);
    #1 chk("R4 mixed source", pin_out, 8'h35);
    chk("R4 oe", pin_oe, 8'hFF);
    alt_out = 8'hC3;
    #1 chk("R4 alt follows peripheral", pin_out, 8'hC5);
    alt_out = 8'h3C;
  endtask

  task automatic t_open_drain();
    sub_wr(8'h03, 8'h0F);
    #1 chk("R5 od latch bits out", pin_out, 8'h30);
    chk("R5 od latch bits oe", pin_oe, 8'hFA);
    sub_wr(8'h03, 8'hF0);
    #1 chk("R6 od alt bits out", pin_out, 8'h05);
    chk("R6 od alt bits oe", pin_oe, 8'hCF);
    sub_wr(8'h01, 8'h01);
    #1 chk("R3 input overrides", pin_oe, 8'hCE);
    sub_wr(8'h01, 8'h00);
    sub_wr(8'h03, 8'h00);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    sub_wr(8'h01, 8'h12);
    sub_wr(8'h02, 8'h34);
    sub_wr(8'h03, 8'h56);
    sub_wr(8'h05, 8'hAA);
    rd(2'd1, v);       chk("R7 read 05h", v, 8'h00);
    sub_wr(8'h00, 8'hBB);
    rd(2'd1, v);       chk("R7 read 00h", v, 8'h00);
    sub_wr(8'hFF, 8'hCC);
    rd(2'd1, v);       chk("R7 read FFh", v, 8'h00);
    sub_rd(8'h01, v);  chk("R7 dir kept", v, 8'h12);
    sub_rd(8'h02, v);  chk("R7 alt kept", v, 8'h34);
    sub_rd(8'h03, v);  chk("R7 od kept", v, 8'h56);
  endtask

  task automatic t_ro_pins();
    logic [7:0] v;
    wr(2'd2, 8'h5A);
    wr(2'd0, 8'h03);
    wr(2'd3, 8'hFF);
    rd(2'd0, v);       chk("R10 index kept", v, 8'h03);
    rd(2'd2, v);       chk("R10 latch kept", v, 8'h5A);
    rd(2'd1, v);       chk("R10 od kept", v, 8'h56);
    rd(2'd3, v);       chk("R10 pins unchanged", v, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    @(negedge clk);
    pin_in = 8'h96;
    @(negedge clk);
    rd(2'd3, v);
    chk("R8 visible after two edges", v, 8'h96);
    pin_in = 8'h69;
    @(posedge clk);
    #1 bus_sel = 1'b1; bus_addr = 2'd3;
    #1 chk("R8 not after one edge", bus_rdata, 8'h96);
    @(posedge clk);
    #1 chk("R8 after second edge", bus_rdata, 8'h69);
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 oe in reset", pin_oe, 8'h00);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_latch();
    t_alt();
    t_open_drain();
    t_unimpl();
    t_ro_pins();
    t_sync();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule